// File: doc/BRIEF.md
# Boost Frequency Controller

This block turns the results of an activity monitor into a requested clock frequency. It keeps a boost term that persists from one request to the next. When the monitor reports a run of samples above its upper watermark, the boost grows by a percentage and a fixed step. When the monitor reports a run of samples below its lower watermark, the boost shrinks by a percentage. The block also works out a sustain frequency from the averaged activity count. The requested frequency is the sustain frequency plus the boost.

Each request carries the breach flags, the average count, the frequency ceiling and the coefficients of one channel. Both the request and the result use a valid/ready handshake. The block serves one request at a time. It raises `in_ready` only while it is idle, which means no request is being computed and no result is waiting to be taken. A result stays on the outputs, with `out_valid` high, until `out_ready` is seen high at a clock edge. While it waits, back-pressure holds every result output steady.

The arithmetic runs one bit per cycle on a shared multiplier and a shared divider. A request therefore takes a few hundred cycles. The result also returns the two breach-interrupt enables, so that firmware can write them back to the monitor.

Top module: `boost_freq_ctl`

## Requirements
- R1: `in_ready` is high only when the block is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `out_valid` and `in_ready` are never high together. While `out_valid` is high and `out_ready` is low, `boost_o`, `target_o`, `above_en_o` and `below_en_o` hold their values.
- R2: When `ev_up` is set, the new boost is floor(boost * `gain_up` / 100) + 16000. If this value is greater than or equal to `freq_max`, the boost becomes `freq_max`.
- R3: When `ev_up` is set, `below_en_o` is 1. `above_en_o` is 1 only if the boost did not reach `freq_max`.
- R4: When only `ev_dn` is set, the new boost is floor(boost * `gain_dn` / 100). If this value is below 8000 (half the step), the boost becomes 0.
- R5: When only `ev_dn` is set, `above_en_o` is 1. `below_en_o` is 1 only if the new boost is nonzero, subject to R8.
- R6: When `ev_up` and `ev_dn` are both set, the request is handled as an upper breach alone.
- R7: When neither flag is set, the boost keeps its value, and `above_en_i` and `below_en_i` pass through to the outputs unchanged, subject to R8.
- R8: When `dep_floor` is nonzero, the following applies last. If `avg_cnt` >= `dep_floor`, then `below_en_o` is forced to 1. Otherwise, if the new boost is 0, `below_en_o` is forced to 0.
- R9: `target_o` = floor(floor(floor(`avg_cnt`/12) * floor(10000/`sustain_pct`)) / 100) + new boost. If the sum does not fit in 32 bits, `target_o` is all ones.
- R10: When `sustain_pct` is 0, the sustain term is 0 and `target_o` equals the new boost.
- R11: After reset, the boost is 0, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle, ready to take a request |
| ev_up | input | 1 | Consecutive upper breach reported |
| ev_dn | input | 1 | Consecutive lower breach reported |
| avg_cnt | input | 32 | Averaged activity count for the sampling period |
| freq_max | input | 32 | Frequency ceiling in kHz |
| gain_up | input | 16 | Growth percentage |
| gain_dn | input | 16 | Decay percentage |
| sustain_pct | input | 16 | Upper-threshold percentage used for the sustain term |
| dep_floor | input | 32 | Average threshold for the dependency rule; 0 turns the rule off |
| above_en_i | input | 1 | Current above-breach interrupt enable |
| below_en_i | input | 1 | Current below-breach interrupt enable |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result accepted |
| boost_o | output | 32 | Updated boost in kHz |
| above_en_o | output | 1 | Updated above-breach enable |
| below_en_o | output | 1 | Updated below-breach enable |
| target_o | output | 32 | Requested frequency in kHz |

## Verification
A wrong boost value corrupts `boost_o` and `target_o` in the very result that first uses it. Because the boost carries over between requests, the error also repeats in every later result until a clamp or a snap to zero covers it up. For this reason the stimulus runs long growth and decay chains in which each result depends on the one before. An error in the sequencer, or in how operands are shared between steps, appears as a wrong target on the first request that exercises it. A handshake error shows up as an output that moves during a stall, or as `in_ready` overlapping `out_valid`.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BMUL,
    ST_BDIV,
    ST_BFIX,
    ST_ADIV,
    ST_KDIV,
    ST_SMUL,
    ST_SDIV,
    ST_FIN,
    ST_HOLD
  } bfc_state_e;
endpackage

// File: rtl/bfc_mul_seq.sv
// Shift-add multiplier, one multiplier bit per cycle.
module bfc_mul_seq #(
  parameter int AW = 32,
  parameter int BW = 16,
  localparam int PW = AW + BW,
  localparam int CW = $clog2(BW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  output logic          done,
  output logic [PW-1:0] prod
);
  logic [PW-1:0] acc_q, mcand_q;
  logic [BW-1:0] mplier_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        acc_q    <= '0;
        mcand_q  <= {{BW{1'b0}}, a};
        mplier_q <= b;
        cnt_q    <= CW'(BW);
        busy_q   <= 1'b1;
      end else if (busy_q) begin
        if (mplier_q[0]) acc_q <= acc_q + mcand_q;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        cnt_q    <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign prod = acc_q;
endmodule

// File: rtl/bfc_div_seq.sv
// Restoring divider, one quotient bit per cycle.
module bfc_div_seq #(
  parameter int NW = 48,
  parameter int DW = 16,
  localparam int CW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quo
);
  logic [DW-1:0] rem_q, den_q;
  logic [NW-1:0] quo_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [DW:0]   trial;
  logic          fits;

  always_comb begin
    trial = {rem_q, quo_q[NW-1]};
    fits  = (trial >= {1'b0, den_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q  <= '0;
        den_q  <= den;
        quo_q  <= num;
        cnt_q  <= CW'(NW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (fits) rem_q <= DW'(trial - {1'b0, den_q});
        else      rem_q <= trial[DW-1:0];
        quo_q <= {quo_q[NW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign quo = quo_q;
endmodule

// File: rtl/bfc_gate_rules.sv
// Next interrupt enables from the breach kind, limit hits and dependency rule.
module bfc_gate_rules #(
  parameter int FREQ_W = 32
) (
  input  logic              up,
  input  logic              dn,
  input  logic              sat_hit,
  input  logic              snap_zero,
  input  logic              above_i,
  input  logic              below_i,
  input  logic [FREQ_W-1:0] avg,
  input  logic [FREQ_W-1:0] dep,
  input  logic              boost_zero,
  output logic              above_o,
  output logic              below_o
);
  always_comb begin
    if (up) begin
      above_o = ~sat_hit;
      below_o = 1'b1;
    end else if (dn) begin
      above_o = 1'b1;
      below_o = ~snap_zero;
    end else begin
      above_o = above_i;
      below_o = below_i;
    end
    if (dep != '0) begin
      if (avg >= dep)      below_o = 1'b1;
      else if (boost_zero) below_o = 1'b0;
    end
  end
endmodule

// File: rtl/boost_freq_ctl.sv
module boost_freq_ctl #(
  parameter int FREQ_W     = 32,
  parameter int COEF_W     = 16,
  parameter int BOOST_STEP = 16000,
  parameter int PERIOD_MS  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              ev_up,
  input  logic              ev_dn,
  input  logic [FREQ_W-1:0] avg_cnt,
  input  logic [FREQ_W-1:0] freq_max,
  input  logic [COEF_W-1:0] gain_up,
  input  logic [COEF_W-1:0] gain_dn,
  input  logic [COEF_W-1:0] sustain_pct,
  input  logic [FREQ_W-1:0] dep_floor,
  input  logic              above_en_i,
  input  logic              below_en_i,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FREQ_W-1:0] boost_o,
  output logic              above_en_o,
  output logic              below_en_o,
  output logic [FREQ_W-1:0] target_o
);
  import bfc_pkg::*;

  localparam int PW        = FREQ_W + COEF_W;
  localparam int HALF_STEP = BOOST_STEP / 2;
  localparam int PCT       = 100;
  localparam int K_NUM     = PCT * PCT;

  bfc_state_e st_q;

  logic              r_up, r_dn, r_ai, r_bi;
  logic [FREQ_W-1:0] r_avg, r_max, r_dep;
  logic [COEF_W-1:0] r_gup, r_gdn, r_thr;

  logic [FREQ_W-1:0] boost_q, boost_n, avg12_q;
  logic [COEF_W-1:0] k_q;
  logic [PW-1:0]     prod_q, quo_q;
  logic              sat_q, snap_q, launched_q;

  logic [FREQ_W-1:0] res_boost, res_target;
  logic              res_ab, res_bl;

  logic              arith, op_start, mul_start, div_start;
  logic [FREQ_W-1:0] mul_a;
  logic [COEF_W-1:0] mul_b;
  logic [PW-1:0]     mul_p, div_n, div_q;
  logic [COEF_W-1:0] div_d;
  logic              mul_done, div_done;
  logic              gate_ab, gate_bl;
  logic [PW:0]       up_sum, tgt_sum;

  // Arithmetic state sequencing: each step fires its unit once.
  always_comb begin
    arith     = (st_q == ST_BMUL) || (st_q == ST_BDIV) || (st_q == ST_ADIV) ||
                (st_q == ST_KDIV) || (st_q == ST_SMUL) || (st_q == ST_SDIV);
    op_start  = arith && !launched_q;
    mul_start = op_start && ((st_q == ST_BMUL) || (st_q == ST_SMUL));
    div_start = op_start && !((st_q == ST_BMUL) || (st_q == ST_SMUL));
    mul_a     = (st_q == ST_BMUL) ? boost_q : avg12_q;
    mul_b     = (st_q == ST_BMUL) ? (r_up ? r_gup : r_gdn) : k_q;
    unique case (st_q)
      ST_ADIV: begin div_n = PW'(r_avg);  div_d = COEF_W'(PERIOD_MS); end
      ST_KDIV: begin div_n = PW'(K_NUM);  div_d = r_thr;              end
      default: begin div_n = prod_q;      div_d = COEF_W'(PCT);       end
    endcase
    up_sum  = {1'b0, quo_q} + (PW+1)'(BOOST_STEP);
    tgt_sum = {1'b0, quo_q} + (PW+1)'(boost_n);
  end

  bfc_mul_seq #(.AW(FREQ_W), .BW(COEF_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(mul_start),
    .a(mul_a), .b(mul_b), .done(mul_done), .prod(mul_p)
  );

  bfc_div_seq #(.NW(PW), .DW(COEF_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(div_n), .den(div_d), .done(div_done), .quo(div_q)
  );

  bfc_gate_rules #(.FREQ_W(FREQ_W)) u_gate (
    .up(r_up), .dn(r_dn), .sat_hit(sat_q), .snap_zero(snap_q),
    .above_i(r_ai), .below_i(r_bi), .avg(r_avg), .dep(r_dep),
    .boost_zero(boost_n == '0), .above_o(gate_ab), .below_o(gate_bl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      r_up       <= 1'b0;
      r_dn       <= 1'b0;
      r_ai       <= 1'b0;
      r_bi       <= 1'b0;
      r_avg      <= '0;
      r_max      <= '0;
      r_dep      <= '0;
      r_gup      <= '0;
      r_gdn      <= '0;
      r_thr      <= '0;
      boost_q    <= '0;
      boost_n    <= '0;
      avg12_q    <= '0;
      k_q        <= '0;
      prod_q     <= '0;
      quo_q      <= '0;
      sat_q      <= 1'b0;
      snap_q     <= 1'b0;
      launched_q <= 1'b0;
      res_boost  <= '0;
      res_target <= '0;
      res_ab     <= 1'b0;
      res_bl     <= 1'b0;
    end else begin
      if (op_start) launched_q <= 1'b1;
      else if (mul_done || div_done) launched_q <= 1'b0;

      unique case (st_q)
        ST_IDLE: if (in_valid) begin
          r_up    <= ev_up;
          r_dn    <= ev_dn & ~ev_up;
          r_ai    <= above_en_i;
          r_bi    <= below_en_i;
          r_avg   <= avg_cnt;
          r_max   <= freq_max;
          r_dep   <= dep_floor;
          r_gup   <= gain_up;
          r_gdn   <= gain_dn;
          r_thr   <= sustain_pct;
          boost_n <= boost_q;
          sat_q   <= 1'b0;
          snap_q  <= 1'b0;
          st_q    <= (ev_up | ev_dn) ? ST_BMUL : ST_ADIV;
        end
        ST_BMUL: if (mul_done) begin
          prod_q <= mul_p;
          st_q   <= ST_BDIV;
        end
        ST_BDIV: if (div_done) begin
          quo_q <= div_q;
          st_q  <= ST_BFIX;
        end
        ST_BFIX: begin
          if (r_up) begin
            if (up_sum >= (PW+1)'(r_max)) begin
              boost_n <= r_max;
              sat_q   <= 1'b1;
            end else begin
              boost_n <= up_sum[FREQ_W-1:0];
            end
          end else begin
            if (quo_q < PW'(HALF_STEP)) begin
              boost_n <= '0;
              snap_q  <= 1'b1;
            end else begin
              boost_n <= quo_q[FREQ_W-1:0];
            end
          end
          st_q <= ST_ADIV;
        end
        ST_ADIV: if (div_done) begin
          avg12_q <= div_q[FREQ_W-1:0];
          if (r_thr == '0) begin
            quo_q <= '0;
            st_q  <= ST_FIN;
          end else begin
            st_q <= ST_KDIV;
          end
        end
        ST_KDIV: if (div_done) begin
          k_q  <= div_q[COEF_W-1:0];
          st_q <= ST_SMUL;
        end
        ST_SMUL: if (mul_done) begin
          prod_q <= mul_p;
          st_q   <= ST_SDIV;
        end
        ST_SDIV: if (div_done) begin
          quo_q <= div_q;
          st_q  <= ST_FIN;
        end
        ST_FIN: begin
          boost_q    <= boost_n;
          res_boost  <= boost_n;
          res_ab     <= gate_ab;
          res_bl     <= gate_bl;
          res_target <= (tgt_sum > (PW+1)'({FREQ_W{1'b1}})) ? {FREQ_W{1'b1}}
                                                            : tgt_sum[FREQ_W-1:0];
          st_q       <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready   = (st_q == ST_IDLE);
  assign out_valid  = (st_q == ST_HOLD);
  assign boost_o    = res_boost;
  assign target_o   = res_target;
  assign above_en_o = res_ab;
  assign below_en_o = res_bl;
endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
  parameter int FREQ_W     = 32,
  parameter int BOOST_STEP = 16000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              ev_up,
  input logic              ev_dn,
  input logic [FREQ_W-1:0] avg_cnt,
  input logic [FREQ_W-1:0] freq_max,
  input logic [FREQ_W-1:0] dep_floor,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FREQ_W-1:0] boost_o,
  input logic              above_en_o,
  input logic              below_en_o,
  input logic [FREQ_W-1:0] target_o
);
  logic              cap_up, cap_dn;
  logic [FREQ_W-1:0] cap_max, cap_avg, cap_dep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_up  <= 1'b0;
      cap_dn  <= 1'b0;
      cap_max <= '0;
      cap_avg <= '0;
      cap_dep <= '0;
    end else if (in_valid && in_ready) begin
      cap_up  <= ev_up;
      cap_dn  <= ev_dn;
      cap_max <= freq_max;
      cap_avg <= avg_cnt;
      cap_dep <= dep_floor;
    end
  end

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_hold_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(boost_o) && $stable(target_o)
                                   && $stable(above_en_o) && $stable(below_en_o)));

  assert_up_ceiling_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_up) |-> (boost_o <= cap_max));

  assert_up_below_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_up && boost_o != '0) |-> below_en_o);

  assert_dn_snap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_dn && !cap_up) |-> (boost_o == '0 || boost_o >= FREQ_W'(BOOST_STEP / 2)));

  assert_dn_above_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_dn && !cap_up) |-> above_en_o);

  assert_dep_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_dep != '0 && cap_avg >= cap_dep) |-> below_en_o);

  assert_target_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (target_o >= boost_o));
endmodule

bind boost_freq_ctl bfc_checker #(.FREQ_W(FREQ_W), .BOOST_STEP(BOOST_STEP)) u_bfc_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .ev_up(ev_up), .ev_dn(ev_dn), .avg_cnt(avg_cnt), .freq_max(freq_max),
  .dep_floor(dep_floor), .out_valid(out_valid), .out_ready(out_ready),
  .boost_o(boost_o), .above_en_o(above_en_o), .below_en_o(below_en_o),
  .target_o(target_o)
);

// File: tb/boost_freq_ctl_bench.sv
`timescale 1ns/1ps
module boost_freq_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, ev_up = 1'b0, ev_dn = 1'b0;
  logic        above_en_i = 1'b0, below_en_i = 1'b0, out_ready = 1'b1;
  logic [31:0] avg_cnt = '0, freq_max = '0, dep_floor = '0;
  logic [15:0] gain_up = '0, gain_dn = '0, sustain_pct = '0;
  logic        in_ready, out_valid, above_en_o, below_en_o;
  logic [31:0] boost_o, target_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  boost_freq_ctl u_boost_freq_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ev_up(ev_up), .ev_dn(ev_dn), .avg_cnt(avg_cnt), .freq_max(freq_max),
    .gain_up(gain_up), .gain_dn(gain_dn), .sustain_pct(sustain_pct),
    .dep_floor(dep_floor), .above_en_i(above_en_i), .below_en_i(below_en_i),
    .out_valid(out_valid), .out_ready(out_ready), .boost_o(boost_o),
    .above_en_o(above_en_o), .below_en_o(below_en_o), .target_o(target_o)
  );

  typedef struct packed {
    logic        up;
    logic        dn;
    logic [31:0] avg;
    logic [31:0] fmax;
    logic [15:0] gup;
    logic [15:0] gdn;
    logic [15:0] thr;
    logic [31:0] dep;
    logic        ai;
    logic        bi;
    logic [31:0] eb;
    logic        ea;
    logic        ebl;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,32'd120000,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd16000,1'b1,1'b1},
    '{1'b1,1'b0,32'd60000, 32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd48000,1'b1,1'b1},
    '{1'b1,1'b0,32'd240000,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd112000,1'b1,1'b1},
    '{1'b1,1'b0,32'd0,     32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd240000,1'b1,1'b1},
    '{1'b1,1'b0,32'd1200,  32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd496000,1'b1,1'b1},
    '{1'b1,1'b0,32'd500000,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd800000,1'b0,1'b1},
    '{1'b0,1'b1,32'd120000,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd400000,1'b1,1'b1},
    '{1'b0,1'b1,32'd120000,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd200000,1'b1,1'b1},
    '{1'b0,1'b1,32'd120000,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd100000,1'b1,1'b1},
    '{1'b0,1'b1,32'd120000,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd50000,1'b1,1'b1},
    '{1'b0,1'b1,32'd120000,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd25000,1'b1,1'b1},
    '{1'b0,1'b1,32'd120000,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd12500,1'b1,1'b1},
    '{1'b0,1'b1,32'd120000,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd0,1'b1,1'b0},
    '{1'b1,1'b1,32'd120000,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd16000,1'b1,1'b1},
    '{1'b0,1'b0,32'd120000,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b1,32'd16000,1'b0,1'b1},
    '{1'b0,1'b1,32'd60000, 32'd800000,16'd800,16'd90,16'd27,32'd50000,1'b0,1'b0,32'd14400,1'b1,1'b1},
    '{1'b0,1'b1,32'd60000, 32'd800000,16'd800,16'd90,16'd27,32'd50000,1'b0,1'b0,32'd12960,1'b1,1'b1},
    '{1'b0,1'b1,32'd1000,  32'd800000,16'd800,16'd90,16'd27,32'd50000,1'b0,1'b0,32'd11664,1'b1,1'b1},
    '{1'b0,1'b1,32'd1000,  32'd800000,16'd800,16'd90,16'd27,32'd50000,1'b0,1'b0,32'd10497,1'b1,1'b1},
    '{1'b0,1'b1,32'd1000,  32'd800000,16'd800,16'd90,16'd27,32'd50000,1'b0,1'b0,32'd9447,1'b1,1'b1},
    '{1'b0,1'b1,32'd1000,  32'd800000,16'd800,16'd90,16'd27,32'd50000,1'b0,1'b0,32'd8502,1'b1,1'b1},
    '{1'b0,1'b1,32'd1000,  32'd800000,16'd800,16'd90,16'd27,32'd50000,1'b0,1'b0,32'd0,1'b1,1'b0},
    '{1'b0,1'b0,32'd70000, 32'd800000,16'd800,16'd90,16'd27,32'd50000,1'b0,1'b0,32'd0,1'b0,1'b1},
    '{1'b0,1'b0,32'd100,   32'd800000,16'd800,16'd90,16'd27,32'd50000,1'b1,1'b1,32'd0,1'b1,1'b0},
    '{1'b1,1'b0,32'd100,   32'd800000,16'd800,16'd90,16'd27,32'd50000,1'b0,1'b0,32'd16000,1'b1,1'b1},
    '{1'b1,1'b0,32'd100,   32'd800000,16'd800,16'd90,16'd27,32'd50000,1'b0,1'b0,32'd144000,1'b1,1'b1},
    '{1'b1,1'b0,32'd100,   32'd800000,16'd800,16'd90,16'd27,32'd50000,1'b0,1'b0,32'd800000,1'b0,1'b1},
    '{1'b1,1'b0,32'd120000,32'd10000, 16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd10000,1'b0,1'b1}
  };

  // Target from R9/R10, given the expected boost.
  function automatic logic [31:0] model_target(input logic [31:0] avg, input logic [15:0] thr,
                                               input logic [31:0] boost);
    longint unsigned sus, tot;
    if (thr == 16'd0) sus = 0;
    else sus = ((longint'(avg) / 12) * (longint'(10000) / longint'(thr))) / 100;
    tot = sus + longint'(boost);
    if (tot > 64'h0000_0000_FFFF_FFFF) return 32'hFFFF_FFFF;
    return tot[31:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input vec_t v);
    ev_up = v.up; ev_dn = v.dn; avg_cnt = v.avg; freq_max = v.fmax;
    gain_up = v.gup; gain_dn = v.gdn; sustain_pct = v.thr; dep_floor = v.dep;
    above_en_i = v.ai; below_en_i = v.bi;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
  endtask

  task automatic run_and_check(input vec_t v, input string bt, input string et, input string bl_t);
    send(v);
    check(bt, boost_o, v.eb);
    check(et, {31'd0, above_en_o}, {31'd0, v.ea});
    check(bl_t, {31'd0, below_en_o}, {31'd0, v.ebl});
    check("R9 target", target_o, model_target(v.avg, v.thr, v.eb));
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vec_t v;
    logic [31:0] hb, ht;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 in_ready", {31'd0, in_ready}, 32'd1);
    check("R11 out_valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 in_ready after release", {31'd0, in_ready}, 32'd1);
    v = '{1'b0,1'b0,32'd120000,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b1,1'b0,32'd0,1'b1,1'b0};
    run_and_check(v, "R11 boost", "R7 above", "R7 below");

    // Stimulus table
    for (int i = 0; i < NV; i++) begin
      string bt, et, blt;
      if (VEC[i].up && VEC[i].dn) begin bt = "R6 boost"; et = "R6 above"; blt = "R6 below"; end
      else if (VEC[i].up) begin bt = "R2 boost"; et = "R3 above"; blt = "R3 below"; end
      else if (VEC[i].dn) begin bt = "R4 boost"; et = "R5 above"; blt = "R5 below"; end
      else begin bt = "R7 boost"; et = "R7 above"; blt = "R7 below"; end
      if (VEC[i].dep != 32'd0) blt = "R8 below";
      run_and_check(VEC[i], bt, et, blt);
    end

    // R1: back-pressure holds the result
    out_ready = 1'b0;
    v = '{1'b0,1'b0,32'd120000,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b1,1'b1,32'd10000,1'b1,1'b1};
    send(v);
    hb = boost_o; ht = target_o;
    check("R1 stalled boost", hb, 32'd10000);
    check("R1 stalled target", ht, model_target(v.avg, v.thr, 32'd10000));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1 out_valid held", {31'd0, out_valid}, 32'd1);
      check("R1 in_ready low", {31'd0, in_ready}, 32'd0);
      check("R1 boost stable", boost_o, hb);
      check("R1 target stable", target_o, ht);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R1 out_valid drop", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready back", {31'd0, in_ready}, 32'd1);

    // R10: zero threshold percentage
    v = '{1'b0,1'b0,32'd120000,32'd800000,16'd200,16'd50,16'd0,32'd0,1'b0,1'b0,32'd10000,1'b0,1'b0};
    send(v);
    check("R10 target", target_o, 32'd10000);
    @(negedge clk);

    // R9: target saturation
    v = '{1'b0,1'b0,32'hFFFF_FFFF,32'd800000,16'd200,16'd50,16'd1,32'd0,1'b0,1'b0,32'd10000,1'b0,1'b0};
    send(v);
    check("R9 saturated target", target_o, 32'hFFFF_FFFF);
    @(negedge clk);

    // R11: reset mid-run clears the boost
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    v = '{1'b0,1'b0,32'd0,32'd800000,16'd200,16'd50,16'd60,32'd0,1'b0,1'b0,32'd0,1'b0,1'b0};
    send(v);
    check("R11 boost cleared", boost_o, 32'd0);
    check("R11 target", target_o, 32'd0);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule